// File: doc/BRIEF.md
# Quad wiper register bank

This block keeps the register state behind four digitally set potentiometers. Each pot owns a volatile 6-bit wiper register, which picks one of 64 taps on its resistor ladder, and four 6-bit data registers. The data registers are modelled as nonvolatile cells: a store into one is held pending until the bus stop condition, and then occupies the block for a timed busy period. A serial bus front end decodes each transaction into a one-cycle command pulse carrying an operation code, a pot number, a register number and a data byte. It also signals the stop condition with `stop_i`.

The command set covers the following operations. Wipers and data registers can be read or written directly. A single data register can be loaded into its own pot's wiper, and one register number can be loaded into all four wipers at once. Wipers can be stored into data registers, for one pot or for all four pots together. Leaving reset, every wiper is recalled from its data register 0. The block drives a one-hot 64-bit tap select for each pot and a busy flag for the store timer.

Top module: `quad_wiper_bank`

## Requirements
- R1: While `rst_ni` is low, every wiper is 0, so bit 0 of each pot's tap field is set. `busy_o` and `rd_valid_o` are low.
- R2: On the first clock edge after reset is released, each wiper takes the value of its own data register 0. Commands sampled on that edge are dropped.
- R3: Pot p owns bits [p*64+63 : p*64] of `tap_sel_o`. Exactly one bit of that field is set: bit w, where w is the pot's wiper value. Value 0 selects the low end and 63 selects the high end.
- R4: Operation 1 (write wiper) loads `cmd_data_i` into the wiper of pot `cmd_pot_i` on the sampling edge. It acts whether `wp_ni` is high or low, and whether the block is busy or not.
- R5: Operation 0 (read wiper) and operation 2 (read data register `cmd_reg_i`) return the value held before the sampling edge. The value appears on `rd_data_o`, and `rd_valid_o` is high for exactly the one cycle after that edge.
- R6: Operation 4 copies data register `cmd_reg_i` of pot `cmd_pot_i` into that pot's wiper on the sampling edge. The other wipers are left unchanged.
- R7: Operation 6 copies data register `cmd_reg_i` of every pot into that pot's wiper on the same edge.
- R8: Three operations are stores:
  - operation 3 (write data register);
  - operation 5 (store one wiper);
  - operation 7 (store all wipers).

  A store does not change any data register when its command arrives. The write lands on the edge where the next `stop_i` is sampled.
- R9: The edge that lands a store raises `busy_o`. `busy_o` then stays high for exactly BUSY_CYCLES cycles.
- R10: A store whose command is sampled with `wp_ni` low is discarded. It changes no data register and does not start the busy timer.
- R11: A store whose command is sampled while `busy_o` is high is discarded. It changes no data register.
- R12: Operations 5 and 7 store the wiper values held when the command was sampled. A wiper change made between that command and the stop does not alter the stored value. Operation 7 writes register `cmd_reg_i` of all four pots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse marking a decoded command |
| cmd_op_i | input | 3 | Operation code 0..7 |
| cmd_pot_i | input | 2 | Target pot |
| cmd_reg_i | input | 2 | Target data register |
| cmd_data_i | input | 6 | Write data |
| stop_i | input | 1 | Bus stop condition seen, one-cycle pulse |
| wp_ni | input | 1 | Write protect, low blocks stores |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 6 | Read data |
| busy_o | output | 1 | Nonvolatile store in progress |
| tap_sel_o | output | 256 | One-hot tap select, 64 bits per pot |

## Verification
The bench aims at the windows in which a store can go wrong, and at what a faulty design would show in each.

- Register contents between a store command and its stop. A design that wrote at once would return the new value early.
- Stores issued during the busy period. A design that accepted them would overwrite data or stretch the busy period.
- Protected stores. A design that honoured only part of the protection would start the timer while writing nothing.
- A wiper change made between a global store and its stop. A design that sampled the wipers late would store the changed value.
- Taps at both ends of the ladder, the exact busy length, and the recall cycle after reset. An off-by-one in any of these shows on the tap select or the busy flag.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DATA  = 3'd2,
    OP_WR_DATA  = 3'd3,
    OP_LD_ONE   = 3'd4,
    OP_ST_ONE   = 3'd5,
    OP_LD_ALL   = 3'd6,
    OP_ST_ALL   = 3'd7
  } op_e;

  function automatic logic is_store(op_e op);
    return (op == OP_WR_DATA) || (op == OP_ST_ONE) || (op == OP_ST_ALL);
  endfunction
endpackage

// File: rtl/qwb_tap_dec.sv
module qwb_tap_dec #(
  parameter int unsigned DW = 6,
  localparam int unsigned TAPS = 1 << DW
) (
  input  logic [DW-1:0]   code_i,
  output logic [TAPS-1:0] tap_o
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_o[i] = (code_i == DW'(i));
  end
endmodule

// File: rtl/qwb_nv_ctrl.sv
module qwb_nv_ctrl #(
  parameter int unsigned BUSY_CYCLES = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic stop_i,
  output logic pend_o,
  output logic commit_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign busy_o   = (cnt_q != '0);
  assign pend_o   = pend_q;
  assign commit_o = stop_i & pend_q & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (commit_o) pend_q <= 1'b0;
    else if (req_i)    pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (commit_o) cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (busy_o)   cnt_q <= cnt_q - 1'b1;
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUSY_CYCLES));

  // R11
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cnt_q < $past(cnt_q)));

  // R9
  busy_from_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_o));
endmodule

// File: rtl/qwb_pot.sv
module qwb_pot #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 6,
  parameter logic [NREG*DW-1:0] INIT = '0,
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned TAPS  = 1 << DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recall_i,
  input  logic             wr_wiper_i,
  input  logic [DW-1:0]    wr_wiper_data_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_sel_i,
  input  logic             dr_we_i,
  input  logic [REG_W-1:0] dr_sel_i,
  input  logic [DW-1:0]    dr_wdata_i,
  input  logic [REG_W-1:0] rd_sel_i,
  output logic [DW-1:0]    wiper_o,
  output logic [DW-1:0]    dr_rdata_o,
  output logic [TAPS-1:0]  tap_o
);
  logic [DW-1:0] dr_q [NREG];
  logic [DW-1:0] wiper_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) dr_q[r] <= INIT[r*DW +: DW];
    end else if (dr_we_i) begin
      dr_q[dr_sel_i] <= dr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wiper_q <= '0;
    else if (recall_i)   wiper_q <= dr_q[0];
    else if (wr_wiper_i) wiper_q <= wr_wiper_data_i;
    else if (ld_i)       wiper_q <= dr_q[ld_sel_i];
  end

  assign wiper_o    = wiper_q;
  assign dr_rdata_o = dr_q[rd_sel_i];

  qwb_tap_dec #(.DW(DW)) u_dec (
    .code_i (wiper_q),
    .tap_o  (tap_o)
  );

  // R3
  onehot_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_o) == 1);

  // R2
  recall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_i |=> (wiper_q == $past(dr_q[0])));
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
  import qwb_pkg::*;
#(
  parameter int unsigned NPOT        = 4,
  parameter int unsigned NREG        = 4,
  parameter int unsigned DW          = 6,
  parameter int unsigned BUSY_CYCLES = 2000000,
  parameter logic [NPOT*NREG*DW-1:0] DR_INIT = '0,
  localparam int unsigned POT_W = $clog2(NPOT),
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned TAPS  = 1 << DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [POT_W-1:0]     cmd_pot_i,
  input  logic [REG_W-1:0]     cmd_reg_i,
  input  logic [DW-1:0]        cmd_data_i,
  input  logic                 stop_i,
  input  logic                 wp_ni,
  output logic                 rd_valid_o,
  output logic [DW-1:0]        rd_data_o,
  output logic                 busy_o,
  output logic [NPOT*TAPS-1:0] tap_sel_o
);
  op_e              op;
  logic             recall_q;
  logic             live;
  logic             store_req;
  logic             pend_w;
  logic             commit_w;
  logic [NPOT-1:0]  pend_mask_q;
  logic [REG_W-1:0] pend_reg_q;
  logic [DW-1:0]    pend_data_q [NPOT];
  logic [DW-1:0]    wiper_w     [NPOT];
  logic [DW-1:0]    dr_rd_w     [NPOT];

  assign op        = op_e'(cmd_op_i);
  assign live      = cmd_valid_i & ~recall_q;
  assign store_req = live & is_store(op) & wp_ni & ~busy_o & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recall_q <= 1'b1;
    else         recall_q <= 1'b0;
  end

  // Store operands are frozen at command time, committed at stop.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_mask_q <= '0;
      pend_reg_q  <= '0;
      for (int p = 0; p < NPOT; p++) pend_data_q[p] <= '0;
    end else if (store_req) begin
      pend_reg_q <= cmd_reg_i;
      for (int p = 0; p < NPOT; p++) begin
        pend_mask_q[p] <= (op == OP_ST_ALL) || (cmd_pot_i == POT_W'(p));
        pend_data_q[p] <= (op == OP_WR_DATA) ? cmd_data_i : wiper_w[p];
      end
    end
  end

  qwb_nv_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_nv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (store_req),
    .stop_i   (stop_i),
    .pend_o   (pend_w),
    .commit_o (commit_w),
    .busy_o   (busy_o)
  );

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic sel;
    assign sel = (cmd_pot_i == POT_W'(p));

    qwb_pot #(
      .NREG (NREG),
      .DW   (DW),
      .INIT (DR_INIT[p*NREG*DW +: NREG*DW])
    ) u_pot (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .recall_i        (recall_q),
      .wr_wiper_i      (live && op == OP_WR_WIPER && sel),
      .wr_wiper_data_i (cmd_data_i),
      .ld_i            (live && ((op == OP_LD_ONE && sel) || op == OP_LD_ALL)),
      .ld_sel_i        (cmd_reg_i),
      .dr_we_i         (commit_w && pend_mask_q[p]),
      .dr_sel_i        (pend_reg_q),
      .dr_wdata_i      (pend_data_q[p]),
      .rd_sel_i        (cmd_reg_i),
      .wiper_o         (wiper_w[p]),
      .dr_rdata_o      (dr_rd_w[p]),
      .tap_o           (tap_sel_o[p*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= live && (op == OP_RD_WIPER || op == OP_RD_DATA);
      if (live && op == OP_RD_WIPER)     rd_data_o <= wiper_w[cmd_pot_i];
      else if (live && op == OP_RD_DATA) rd_data_o <= dr_rd_w[cmd_pot_i];
    end
  end

  // R8
  busy_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  // R5
  rd_follows_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i));

  // R10
  wp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !wp_ni && !pend_w && !recall_q) |=> !pend_w);
endmodule

// File: tb/quad_wiper_bank_tb.sv
`timescale 1ns/1ps
module quad_wiper_bank_tb;
  localparam int BUSY = 20;

  function automatic int fval(int p, int r);
    return (p * 16 + r * 5 + 3) % 64;
  endfunction

  function automatic logic [95:0] mk_init();
    logic [95:0] v;
    v = '0;
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) v[(p*4+r)*6 +: 6] = 6'(fval(p, r));
    return v;
  endfunction

  localparam logic [95:0] INIT = mk_init();

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [1:0]   cmd_pot = '0;
  logic [1:0]   cmd_reg = '0;
  logic [5:0]   cmd_data = '0;
  logic         stop = 1'b0;
  logic         wp_n = 1'b1;
  logic         rd_valid;
  logic [5:0]   rd_data;
  logic         busy;
  logic [255:0] tap;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  started = 0;

  always #2.5 clk = ~clk;

  quad_wiper_bank #(.BUSY_CYCLES(BUSY), .DR_INIT(INIT)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_pot_i   (cmd_pot),
    .cmd_reg_i   (cmd_reg),
    .cmd_data_i  (cmd_data),
    .stop_i      (stop),
    .wp_ni       (wp_n),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .busy_o      (busy),
    .tap_sel_o   (tap)
  );

  // Behavioural reference
  int mdr [4][4];
  int mw [4];
  int mbusy;
  bit mrecall;
  bit mpend;
  bit pmask [4];
  int preg;
  int pdat [4];
  bit mrdv;
  int mrd;

  always @(posedge clk) begin
    int ob;
    started = 1;
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        mw[p] = 0;
        for (int r = 0; r < 4; r++) mdr[p][r] = fval(p, r);
      end
      mbusy = 0; mrecall = 1; mpend = 0; mrdv = 0;
    end else begin
      mrdv = 0;
      if (mrecall) begin
        for (int p = 0; p < 4; p++) mw[p] = mdr[p][0];
        mrecall = 0;
      end else begin
        ob = mbusy;
        if (cmd_valid) begin
          case (cmd_op)
            3'd0: begin mrdv = 1; mrd = mw[cmd_pot]; end
            3'd2: begin mrdv = 1; mrd = mdr[cmd_pot][cmd_reg]; end
            3'd1: mw[cmd_pot] = cmd_data;
            3'd4: mw[cmd_pot] = mdr[cmd_pot][cmd_reg];
            3'd6: for (int p = 0; p < 4; p++) mw[p] = mdr[p][cmd_reg];
            default: ;
          endcase
        end
        if (stop && mpend && ob == 0) begin
          for (int p = 0; p < 4; p++) if (pmask[p]) mdr[p][preg] = pdat[p];
          mbusy = BUSY; mpend = 0;
        end else if (mbusy > 0) begin
          mbusy--;
        end
        if (cmd_valid && (cmd_op == 3 || cmd_op == 5 || cmd_op == 7)
            && wp_n && ob == 0 && !stop) begin
          preg = cmd_reg; mpend = 1;
          for (int p = 0; p < 4; p++) begin
            pmask[p] = (cmd_op == 7) || (cmd_pot == 2'(p));
            pdat[p]  = (cmd_op == 3) ? int'(cmd_data) : mw[p];
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      for (int p = 0; p < 4; p++) begin
        checks++;
        if (tap[p*64 +: 64] !== (64'd1 << mw[p])) begin
          errors++;
          $display("FAIL R3 pot %0d actual=%h expected=%h", p, tap[p*64 +: 64], 64'd1 << mw[p]);
        end
      end
      chk(busy === (mbusy != 0), "R9 busy", int'(busy), int'(mbusy != 0));
      chk(rd_valid === mrdv, "R5 rd_valid", int'(rd_valid), int'(mrdv));
      if (mrdv) chk(rd_data === 6'(mrd), "R5 rd_data", int'(rd_data), mrd);
    end
  end

  task automatic cmd(input int op, input int pot, input int rg, input int d);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pot = 2'(pot); cmd_reg = 2'(rg); cmd_data = 6'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic rd_chk(input int op, input int pot, input int rg, input int exp, input string tag);
    cmd(op, pot, rg, 0);
    chk(rd_valid === 1'b1 && rd_data === 6'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int p = 0; p < 4; p++)
      chk(tap[p*64 +: 64] === 64'd1, "R1 tap", int'(tap[p*64]), 1);
    chk(busy === 1'b0 && rd_valid === 1'b0, "R1 flags", int'(busy | rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 recall from register 0
    for (int p = 0; p < 4; p++)
      chk(tap[p*64 + fval(p, 0)] === 1'b1, "R2 recall", int'(tap[p*64 + fval(p, 0)]), 1);

    cmd(1, 1, 0, 63);
    chk(tap[127] === 1'b1, "R4 R3 high end", int'(tap[127]), 1);
    cmd(1, 0, 0, 0);
    chk(tap[0] === 1'b1, "R3 low end", int'(tap[0]), 1);
    rd_chk(0, 1, 0, 63, "R5 read wiper");
    @(negedge clk);
    chk(rd_valid === 1'b0, "R5 single pulse", int'(rd_valid), 0);

    cmd(4, 2, 3, 0);
    rd_chk(0, 2, 0, fval(2, 3), "R6 load one");
    rd_chk(0, 3, 0, fval(3, 0), "R6 others kept");

    cmd(6, 0, 2, 0);
    for (int p = 0; p < 4; p++) rd_chk(0, p, 0, fval(p, 2), "R7 load all");

    // R8 deferred store, R9 busy length
    cmd(3, 0, 1, 42);
    rd_chk(2, 0, 1, fval(0, 1), "R8 before stop");
    chk(busy === 1'b0, "R8 idle before stop", int'(busy), 0);
    do_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == BUSY, "R9 busy length", n, BUSY);
    rd_chk(2, 0, 1, 42, "R8 after stop");

    // R11 store while busy
    cmd(3, 0, 0, 1);
    do_stop();
    cmd(3, 3, 0, 17);
    do_stop();
    cmd(1, 2, 0, 7);
    rd_chk(0, 2, 0, 7, "R4 wiper write while busy");
    wait_idle();
    rd_chk(2, 3, 0, fval(3, 0), "R11 dropped");
    @(negedge clk);
    chk(busy === 1'b0, "R11 no extra busy", int'(busy), 0);

    // R10 write protect
    wp_n = 1'b0;
    cmd(3, 1, 2, 5);
    do_stop();
    chk(busy === 1'b0, "R10 no busy", int'(busy), 0);
    rd_chk(2, 1, 2, fval(1, 2), "R10 data kept");
    cmd(1, 1, 0, 9);
    rd_chk(0, 1, 0, 9, "R10 R4 wiper unaffected");
    wp_n = 1'b1;

    // R12 global store captures wipers at command time
    for (int p = 0; p < 4; p++) cmd(1, p, 0, 10 * (p + 1));
    cmd(7, 0, 3, 0);
    cmd(1, 0, 0, 60);
    do_stop();
    wait_idle();
    for (int p = 0; p < 4; p++) rd_chk(2, p, 3, 10 * (p + 1), "R12 store all");

    cmd(5, 2, 1, 0);
    do_stop();
    wait_idle();
    rd_chk(2, 2, 1, 30, "R12 store one");
    rd_chk(2, 1, 1, fval(1, 1), "R12 neighbour kept");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule